// File: doc/BRIEF.md
# JTAG Scan Sequencer

This block is a JTAG master for a single target device. It generates TCK from the system clock and drives TMS and TDI. It also samples TDO. A host issues one command at a time: a five-cycle reset, a reset followed by entry to Run-Test/Idle, an 8-bit instruction scan, a data scan of up to `BUF_BITS` bits with an optional dwell in Pause-DR, or a run of idle clocks. Every scan starts and ends in Run-Test/Idle.

Scan data comes in on `cmd_data` and is loaded into an internal buffer. It is sent least-significant bit first. Each bit sampled from TDO overwrites the bit just sent, at the same position. Bits above the scan length keep their loaded values. When the command finishes, `done` pulses and the buffer appears on `rsp_data`. For an instruction scan, the captured instruction-register bits serve as the device's status.

The TCK period is set by `cfg_half_div`: each phase lasts `cfg_half_div+1` system clocks. TCK stays high whenever the sequencer is idle.

Top module: `jtag_scan_seq`

## Requirements
- R1: Op code 0 (reset) issues exactly 5 TCK cycles with TMS high. This brings the target to Test-Logic-Reset from any state. TDI stays low.
- R2: Op code 1 (reset-to-idle) issues the 5 reset cycles and then one more with TMS low, for 6 cycles in total. The target ends in Run-Test/Idle.
- R3: Op code 2 (instruction scan) takes 14 TCK cycles. The TMS pattern is 1, then 1,0,0, then 8 shift cycles with TMS high only on the last, then 1,0. The target's instruction register is updated with `cmd_data[7:0]`, sent LSB first, and the target ends in Run-Test/Idle.
- R4: After an instruction scan, `rsp_data[7:0]` holds the 8 bits captured from TDO, with bit 0 the first bit captured. `rsp_data` above bit 7 equals `cmd_data`.
- R5: Op code 3 (data scan) with `cmd_count` = 0 takes 3 + `cmd_len` + 2 TCK cycles. The TMS pattern is 1,0,0, then the shift bits with TMS high only on the last, then 1,0. The target's data register is updated with `cmd_data` bits 0 to `cmd_len`-1, sent in that order. `cmd_len` must lie in 1..`BUF_BITS`.
- R6: After a data scan, `rsp_data` bit i holds the i-th bit captured from TDO for every i < `cmd_len`. All higher bits equal `cmd_data`.
- R7: A data scan with `cmd_count` = P > 0 adds 1 + P cycles. One cycle with TMS low enters Pause-DR. The target then spends exactly P rising edges in Pause-DR, with TMS high only on the last, before the 1,0 exit.
- R8: Op code 4 (idle clocks) issues exactly `cmd_count` TCK cycles with TMS and TDI both low. A count of 0 completes with no TCK cycle.
- R9: TMS and TDI change only while TCK is high and has already been high for one system clock. Each TCK low phase lasts exactly `cfg_half_div`+1 system clocks. Each high phase during a command lasts at least that long. TCK is high whenever `busy` is low.
- R10: A command is accepted when `cmd_valid` is high and `busy` is low. `busy` is high from the next cycle until the cycle in which `done` pulses for one cycle. `cmd_valid` is ignored while `busy` is high.
- R11: Op codes 5 to 7 complete with a `done` pulse and no TCK cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_half_div | input | DIV_W | TCK phase length minus one, in system clocks |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Operation code |
| cmd_len | input | LEN_W | Data-scan length in bits |
| cmd_count | input | CNT_W | Pause dwell for data scans, or number of idle clocks |
| cmd_data | input | BUF_BITS | Bits to shift out, LSB first |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_data | output | BUF_BITS | Buffer after capture |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to target |
| tdo | input | 1 | Test data from target |

## Verification
The bench builds the block with `BUF_BITS` = 64, which keeps full-width scans short. Scan lengths are exercised at 1, at the full 64 bits, and at random lengths in between. A behavioural TAP model stands in for the target and follows every TMS edge, so state tracking, the captured bits and the dwell in Pause-DR are checked directly.

`cfg_half_div` is run at 1 and then at 3. This shows that the low phase follows the divider exactly, and that TMS and TDI never move while TCK is low, at either rate.

// File: rtl/jtseq_pkg.sv
package jtseq_pkg;

    typedef enum logic [2:0] {
        OP_RESET      = 3'd0,
        OP_RESET_IDLE = 3'd1,
        OP_IR_SCAN    = 3'd2,
        OP_DR_SCAN    = 3'd3,
        OP_IDLE_CLK   = 3'd4
    } op_e;

    typedef enum logic [3:0] {
        SG_DONE,
        SG_RESET,
        SG_TO_IDLE,
        SG_IR_SEL,
        SG_ENTRY,
        SG_SHIFT,
        SG_PAUSE_IN,
        SG_PAUSE,
        SG_EXIT,
        SG_CLOCKS
    } seg_e;

    localparam int RESET_CYCLES = 5;
    localparam int ENTRY_CYCLES = 3;
    localparam int EXIT_CYCLES  = 2;

    function automatic seg_e first_seg(input logic [2:0] op, input logic count_zero);
        case (op)
            OP_RESET, OP_RESET_IDLE: first_seg = SG_RESET;
            OP_IR_SCAN:              first_seg = SG_IR_SEL;
            OP_DR_SCAN:              first_seg = SG_ENTRY;
            OP_IDLE_CLK:             first_seg = count_zero ? SG_DONE : SG_CLOCKS;
            default:                 first_seg = SG_DONE;
        endcase
    endfunction

endpackage

// File: rtl/jtseq_phase_timer.sv
module jtseq_phase_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    logic [DIV_W-1:0] tcnt;

    assign tick = run && (tcnt == half_div);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            tcnt <= '0;
        end else begin
            tcnt <= tcnt + 1'b1;
        end
    end

    // Counter must restart from zero on every phase boundary (R9)
    assert_phase_restart_R9: assert property (@(posedge clk) disable iff (rst)
        $past(tick) |-> (tcnt == '0));
endmodule

// File: rtl/jtseq_shift_buf.sv
module jtseq_shift_buf #(
    parameter int BITS = 512
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load,
    input  logic [BITS-1:0]           load_data,
    input  logic                      cap_en,
    input  logic [$clog2(BITS)-1:0]   idx,
    input  logic                      cap_bit,
    output logic [BITS-1:0]           data,
    output logic                      out_bit
);
    assign out_bit = data[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
        end else if (load) begin
            data <= load_data;
        end else if (cap_en) begin
            data[idx] <= cap_bit;
        end
    end

    // A capture touches only the addressed bit (R6)
    assert_single_bit_R6: assert property (@(posedge clk) disable iff (rst)
        $past(cap_en) && !$past(load) |-> ($countones(data ^ $past(data)) <= 1));
endmodule

// File: rtl/jtseq_step_gen.sv
module jtseq_step_gen
    import jtseq_pkg::*;
#(
    parameter int SEQ_W = 16
) (
    input  seg_e             seg,
    input  logic [SEQ_W-1:0] cnt,
    input  logic [SEQ_W-1:0] bits_m1,
    input  logic [SEQ_W-1:0] count_m1,
    input  logic             pause_en,
    input  logic             to_idle,
    input  logic             data_bit,
    output logic             step_tms,
    output logic             step_tdi,
    output logic             step_last,
    output seg_e             step_next
);
    always_comb begin
        step_tms  = 1'b0;
        step_tdi  = 1'b0;
        step_last = 1'b1;
        step_next = SG_DONE;
        case (seg)
            SG_RESET: begin
                step_tms  = 1'b1;
                step_last = (cnt == SEQ_W'(RESET_CYCLES - 1));
                step_next = to_idle ? SG_TO_IDLE : SG_DONE;
            end
            SG_TO_IDLE: begin
                step_next = SG_DONE;
            end
            SG_IR_SEL: begin
                step_tms  = 1'b1;
                step_next = SG_ENTRY;
            end
            SG_ENTRY: begin
                step_tms  = (cnt == '0);
                step_last = (cnt == SEQ_W'(ENTRY_CYCLES - 1));
                step_next = SG_SHIFT;
            end
            SG_SHIFT: begin
                step_tdi  = data_bit;
                step_tms  = (cnt == bits_m1);
                step_last = (cnt == bits_m1);
                step_next = pause_en ? SG_PAUSE_IN : SG_EXIT;
            end
            SG_PAUSE_IN: begin
                step_next = SG_PAUSE;
            end
            SG_PAUSE: begin
                step_tms  = (cnt == count_m1);
                step_last = (cnt == count_m1);
                step_next = SG_EXIT;
            end
            SG_EXIT: begin
                step_tms  = (cnt == '0);
                step_last = (cnt == SEQ_W'(EXIT_CYCLES - 1));
                step_next = SG_DONE;
            end
            SG_CLOCKS: begin
                step_last = (cnt == count_m1);
                step_next = SG_DONE;
            end
            default: begin
                step_next = SG_DONE;
            end
        endcase
    end
endmodule

// File: rtl/jtag_scan_seq.sv
module jtag_scan_seq
    import jtseq_pkg::*;
#(
    parameter int BUF_BITS = 512,
    parameter int IR_BITS  = 8,
    parameter int CNT_W    = 16,
    parameter int DIV_W    = 8,
    localparam int LEN_W   = $clog2(BUF_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DIV_W-1:0]    cfg_half_div,
    input  logic                cmd_valid,
    input  logic [2:0]          cmd_op,
    input  logic [LEN_W-1:0]    cmd_len,
    input  logic [CNT_W-1:0]    cmd_count,
    input  logic [BUF_BITS-1:0] cmd_data,
    output logic                busy,
    output logic                done,
    output logic [BUF_BITS-1:0] rsp_data,
    output logic                tck,
    output logic                tms,
    output logic                tdi,
    input  logic                tdo
);
    localparam int SEQ_W = (CNT_W > LEN_W) ? CNT_W : LEN_W;
    localparam int IDX_W = $clog2(BUF_BITS);

    seg_e             seg;
    logic [SEQ_W-1:0] cnt;
    logic [SEQ_W-1:0] bits_m1_q;
    logic [SEQ_W-1:0] count_m1_q;
    logic             pause_en_q;
    logic             to_idle_q;
    logic             pend;

    logic             accept;
    logic             run;
    logic             tick;
    logic             cap_en;
    logic             buf_bit;
    logic             step_tms;
    logic             step_tdi;
    logic             step_last;
    seg_e             step_next;

    assign accept = cmd_valid && !busy;
    assign run    = busy && !pend;
    assign cap_en = run && tick && !tck && (seg == SG_SHIFT);

    jtseq_phase_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .half_div (cfg_half_div),
        .tick     (tick)
    );

    jtseq_shift_buf #(.BITS(BUF_BITS)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .load_data (cmd_data),
        .cap_en    (cap_en),
        .idx       (cnt[IDX_W-1:0]),
        .cap_bit   (tdo),
        .data      (rsp_data),
        .out_bit   (buf_bit)
    );

    jtseq_step_gen #(.SEQ_W(SEQ_W)) u_step (
        .seg       (seg),
        .cnt       (cnt),
        .bits_m1   (bits_m1_q),
        .count_m1  (count_m1_q),
        .pause_en  (pause_en_q),
        .to_idle   (to_idle_q),
        .data_bit  (buf_bit),
        .step_tms  (step_tms),
        .step_tdi  (step_tdi),
        .step_last (step_last),
        .step_next (step_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            done       <= 1'b0;
            pend       <= 1'b0;
            seg        <= SG_DONE;
            cnt        <= '0;
            bits_m1_q  <= '0;
            count_m1_q <= '0;
            pause_en_q <= 1'b0;
            to_idle_q  <= 1'b0;
            tck        <= 1'b1;
            tms        <= 1'b0;
            tdi        <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (cmd_valid) begin
                    busy       <= 1'b1;
                    pend       <= 1'b1;
                    seg        <= first_seg(cmd_op, cmd_count == '0);
                    cnt        <= '0;
                    bits_m1_q  <= (cmd_op == OP_IR_SCAN) ? SEQ_W'(IR_BITS - 1)
                                                         : SEQ_W'(cmd_len) - SEQ_W'(1);
                    count_m1_q <= SEQ_W'(cmd_count) - SEQ_W'(1);
                    pause_en_q <= (cmd_op == OP_DR_SCAN) && (cmd_count != '0);
                    to_idle_q  <= (cmd_op == OP_RESET_IDLE);
                end
            end else if (pend) begin
                pend <= 1'b0;
                if (seg == SG_DONE) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    tms  <= 1'b0;
                    tdi  <= 1'b0;
                end else begin
                    tms <= step_tms;
                    tdi <= step_tdi;
                end
            end else if (tick) begin
                if (tck) begin
                    tck <= 1'b0;
                end else begin
                    tck  <= 1'b1;
                    pend <= 1'b1;
                    if (step_last) begin
                        seg <= step_next;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end

    // TCK rests high outside a command (R9)
    assert_tck_idle_high_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tck);
    // TMS and TDI move only inside a high phase (R9)
    assert_tms_on_high_R9: assert property (@(posedge clk) disable iff (rst)
        (tms != $past(tms)) |-> (tck && $past(tck)));
    assert_tdi_on_high_R9: assert property (@(posedge clk) disable iff (rst)
        (tdi != $past(tdi)) |-> (tck && $past(tck)));
    // done is a single pulse that ends a busy period (R10)
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));
    // TCK falls only while a command runs (R9)
    assert_fall_in_cmd_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(tck) |-> busy);
endmodule

// File: tb/jtag_scan_seq_tb_top.sv
module jtag_scan_seq_tb_top;
    localparam int BUF   = 64;
    localparam int LEN_W = $clog2(BUF + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [7:0]       cfg_half_div = 8'd1;
    logic             cmd_valid = 1'b0;
    logic [2:0]       cmd_op = '0;
    logic [LEN_W-1:0] cmd_len = '0;
    logic [15:0]      cmd_count = '0;
    logic [BUF-1:0]   cmd_data = '0;
    logic             busy, done, tck, tms, tdi;
    logic             tdo = 1'b0;
    logic [BUF-1:0]   rsp_data;

    always #5 clk = ~clk;

    jtag_scan_seq #(.BUF_BITS(BUF), .IR_BITS(8), .CNT_W(16), .DIV_W(8)) dut_i (
        .clk(clk), .rst(rst), .cfg_half_div(cfg_half_div), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_len(cmd_len), .cmd_count(cmd_count), .cmd_data(cmd_data),
        .busy(busy), .done(done), .rsp_data(rsp_data),
        .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo));

    int n_checks = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- target TAP model ----------------
    localparam int TLR = 0, RTI = 1, SDR = 2, CDR = 3, SHD = 4, E1D = 5, PDR = 6, E2D = 7,
                   UDR = 8, SIR = 9, CIR = 10, SHI = 11, E1I = 12, PIR = 13, E2I = 14, UIR = 15;
    localparam logic [7:0] IR_CAPT = 8'h35;

    int          tstate = SHD;
    logic [63:0] dr_sr = '0, dr_upd = '0, capv = '0;
    logic [7:0]  ir_sr = '0, ir_upd = '0;
    int          rises = 0, pause_edges = 0, tms_hi = 0, tdi_hi = 0;

    function automatic int nxt(input int s, input logic m);
        case (s)
            TLR: return m ? TLR : RTI;
            RTI: return m ? SDR : RTI;
            SDR: return m ? SIR : CDR;
            CDR: return m ? E1D : SHD;
            SHD: return m ? E1D : SHD;
            E1D: return m ? UDR : PDR;
            PDR: return m ? E2D : PDR;
            E2D: return m ? UDR : SHD;
            UDR: return m ? SDR : RTI;
            SIR: return m ? TLR : CIR;
            CIR: return m ? E1I : SHI;
            SHI: return m ? E1I : SHI;
            E1I: return m ? UIR : PIR;
            PIR: return m ? E2I : PIR;
            E2I: return m ? UIR : SHI;
            default: return m ? SDR : RTI;
        endcase
    endfunction

    always @(posedge tck) begin
        if (!rst) begin
            rises++;
            if (tms) tms_hi++;
            if (tdi) tdi_hi++;
            case (tstate)
                CDR: dr_sr <= capv;
                SHD: dr_sr <= {tdi, dr_sr[63:1]};
                PDR: pause_edges++;
                UDR: dr_upd <= dr_sr;
                CIR: ir_sr <= IR_CAPT;
                SHI: ir_sr <= {tdi, ir_sr[7:1]};
                UIR: ir_upd <= ir_sr;
                default: ;
            endcase
            tstate <= nxt(tstate, tms);
        end
    end

    always @(negedge tck) begin
        if (!rst) tdo <= (tstate == SHD) ? dr_sr[0] : (tstate == SHI) ? ir_sr[0] : 1'b0;
    end

    // ---------------- phase timing monitor ----------------
    int   run_len = 0, bad_lo = 0, bad_hi = 0, pin_viol = 0;
    logic p_tck = 1'b1, p_tms = 1'b0, p_tdi = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (tck != p_tck) begin
                if (tck && run_len != int'(cfg_half_div) + 1) bad_lo++;
                if (!tck && run_len < int'(cfg_half_div) + 1) bad_hi++;
                run_len = 1;
            end else begin
                run_len++;
            end
            if ((tms != p_tms || tdi != p_tdi) && !(tck && p_tck)) pin_viol++;
        end
        p_tck = tck; p_tms = tms; p_tdi = tdi;
    end

    // ---------------- command driver ----------------
    int done_seen = 0;
    task automatic run_cmd(input logic [2:0] op, input int len, input int count,
                           input logic [63:0] data);
        int guard;
        rises = 0; pause_edges = 0; tms_hi = 0; tdi_hi = 0; done_seen = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_len = LEN_W'(len);
        cmd_count = 16'(count); cmd_data = data;
        @(negedge clk);
        cmd_valid = 1'b0;
        guard = 0;
        while (!done && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        if (done) done_seen = 1;
    endtask

    function automatic logic [63:0] lenmask(input int len);
        return (len >= 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << len) - 64'd1);
    endfunction

    task automatic do_dr(input int len, input int pz, input logic [63:0] data, input logic [63:0] cv);
        logic [63:0] m;
        capv = cv;
        m = lenmask(len);
        run_cmd(3'd3, len, pz, data);
        chk(done_seen == 1, "R10", "dr done", 64'(done_seen), 64'd1);
        chk(rises == 5 + len + ((pz != 0) ? 1 + pz : 0), "R5", "dr tck cycles",
            64'(rises), 64'(5 + len + ((pz != 0) ? 1 + pz : 0)));
        chk(((dr_upd >> (64 - len)) & m) == (data & m), "R5", "dr update value",
            (dr_upd >> (64 - len)) & m, data & m);
        chk(rsp_data == ((cv & m) | (data & ~m)), "R6", "dr response",
            rsp_data, (cv & m) | (data & ~m));
        chk(pause_edges == pz, "R7", "pause dwell", 64'(pause_edges), 64'(pz));
        chk(tstate == RTI, "R5", "dr end state", 64'(tstate), 64'(RTI));
    endtask

    task automatic do_ir(input logic [7:0] code, input logic [63:0] data);
        logic [63:0] full;
        full = {data[63:8], code};
        run_cmd(3'd2, 0, 0, full);
        chk(rises == 14, "R3", "ir tck cycles", 64'(rises), 64'd14);
        chk(ir_upd == code, "R3", "ir update", 64'(ir_upd), 64'(code));
        chk(tstate == RTI, "R3", "ir end state", 64'(tstate), 64'(RTI));
        chk(rsp_data == {data[63:8], IR_CAPT}, "R4", "ir response",
            rsp_data, {data[63:8], IR_CAPT});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        int unsigned r0;
        r0 = $urandom(32'd4242);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 0 && done == 0, "R10", "reset busy/done", {62'd0, busy, done}, 64'd0);
        chk(tck == 1, "R9", "reset tck high", 64'(tck), 64'd1);

        // R1: reset from the middle of Shift-DR
        run_cmd(3'd0, 0, 0, 64'd0);
        chk(rises == 5 && tms_hi == 5 && tdi_hi == 0, "R1", "reset cycles",
            64'(rises), 64'd5);
        chk(tstate == TLR, "R1", "reset end state", 64'(tstate), 64'(TLR));

        // R2
        run_cmd(3'd1, 0, 0, 64'd0);
        chk(rises == 6 && tms_hi == 5, "R2", "reset-idle cycles", 64'(rises), 64'd6);
        chk(tstate == RTI, "R2", "reset-idle end state", 64'(tstate), 64'(RTI));

        // R3 / R4
        do_ir(8'hA6, 64'h0123_4567_89AB_CDEF);
        for (int i = 0; i < 4; i++) do_ir(8'($urandom), {$urandom, $urandom});

        // R5 / R6 / R7 directed boundaries
        do_dr(1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
        do_dr(64, 0, 64'hDEAD_BEEF_0BAD_F00D, 64'h5A5A_1234_8765_C3C3);
        do_dr(7, 1, 64'h55, 64'h2A);
        for (int i = 0; i < 20; i++) begin
            do_dr(1 + int'($urandom % 64), int'($urandom % 7), {$urandom, $urandom}, {$urandom, $urandom});
        end

        // R8
        run_cmd(3'd4, 0, 9, 64'hFFFF);
        chk(rises == 9 && tms_hi == 0 && tdi_hi == 0, "R8", "idle clocks",
            {32'(rises), 16'(tms_hi), 16'(tdi_hi)}, {32'd9, 32'd0});
        chk(tstate == RTI, "R8", "idle end state", 64'(tstate), 64'(RTI));
        run_cmd(3'd4, 0, 0, 64'd0);
        chk(done_seen == 1 && rises == 0, "R8", "zero idle clocks", 64'(rises), 64'd0);

        // R11
        run_cmd(3'd6, 5, 5, 64'd0);
        chk(done_seen == 1 && rises == 0, "R11", "undefined op", 64'(rises), 64'd0);

        // R10: a second request while busy is ignored
        rises = 0; tms_hi = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd4; cmd_count = 16'd7;
        @(negedge clk);
        cmd_op = 3'd0;
        chk(busy == 1, "R10", "busy after accept", 64'(busy), 64'd1);
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        repeat (40) @(negedge clk);
        chk(rises == 7 && tms_hi == 0 && busy == 0, "R10", "request while busy ignored",
            64'(rises), 64'd7);
        chk(tstate == RTI, "R10", "no reset executed", 64'(tstate), 64'(RTI));

        // R9 with a slower divider
        cfg_half_div = 8'd3;
        do_dr(13, 3, {$urandom, $urandom}, {$urandom, $urandom});
        do_ir(8'h3C, 64'd0);
        chk(bad_lo == 0, "R9", "low phase length", 64'(bad_lo), 64'd0);
        chk(bad_hi == 0, "R9", "high phase length", 64'(bad_hi), 64'd0);
        chk(pin_viol == 0, "R9", "pin change while tck low", 64'(pin_viol), 64'd0);
        chk(tck == 1, "R9", "tck idle high", 64'(tck), 64'd1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule